// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of 32 general-purpose pins behind a 32-bit register port. Each pin can be driven from a software-written output value when its drive enable is set. Otherwise the pin is an input and reads back through a synchronised sample register. A pull-resistor enable and a pull direction for each pin are held in registers and presented unchanged to the pad ring.

Each pin also has its own interrupt detector, set up by three independent bits:
- a sense-mode bit that chooses level or edge;
- a both-edges bit;
- a polarity bit that means rising/high when set and falling/low when clear.

An event on a pin sets a sticky raw status bit. Software can read that bit directly, or read it ANDed with a per-pin enable. It clears the bit by writing a one to a separate acknowledge address. A single interrupt line is the OR of all enabled pending bits.

The register port has no handshake. A write lands on the clock edge where `wr_en_i` is high. Read data is a combinational function of `addr_i`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every writable register and every raw status bit is zero. `irq_o`, `pin_out_o`, `pin_oe_o`, `pull_en_o` and `pull_up_o` are all low.
- R2: Offset 0x00 returns the pin inputs after a two-flop synchroniser. A change set up before clock edge k is not yet visible after edge k, and is visible after edge k+1. Bit n of every per-pin register belongs to pin n.
- R3: Offset 0x04 holds output values and offset 0x08 holds drive enables; both read back. `pin_oe_o` equals the enable register, and `pin_out_o` bit n equals output value n ANDed with enable n.
- R4: Offset 0x38 holds the pull enables (1 = resistor on) and offset 0x34 holds the pull directions (1 = up, 0 = down). They appear on `pull_en_o` and `pull_up_o` and read back.
- R5: With sense mode 0 (edge, offset 0x0C) and both-edges 0 (offset 0x10), polarity 1 (offset 0x14) latches status on a rising synchronised edge only. Polarity 0 latches on a falling edge only.
- R6: With both-edges 1 in edge mode, rising and falling edges both latch status, whatever the polarity bit holds.
- R7: With sense mode 1 (level), status is set on every cycle the synchronised input equals the polarity bit (1 = high active, 0 = low active). An acknowledge has no lasting effect while that level persists.
- R8: Offset 0x1C returns raw status whatever the enables hold. Offset 0x20 returns raw status ANDed with the enable register at offset 0x18.
- R9: Writing a 1 to a bit at offset 0x24 clears that raw status bit, and writing 0 leaves it unchanged. Offset 0x24 reads as zero. If a new event on a pin coincides with its acknowledge, the status stays set.
- R10: `irq_o` is high exactly when some bit is both raw-status set and enabled.
- R11: Reads of offsets outside the map return zero. Writes to offsets 0x00, 0x1C and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the current address |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pin_in_i | input | 32 | Raw pin inputs |
| pin_out_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin drive enables |
| pull_en_o | output | 32 | Pull-resistor enables |
| pull_up_o | output | 32 | Pull direction, 1 = up |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The assertions check on every cycle that raw status is sticky and appears only in a cycle after a detected event. They also check that an acknowledge without a coinciding event clears its bit one cycle later, that the interrupt line never rises with all enables off, and that the acknowledge offset reads zero. Which event each mode recognises needs the bench's directed scenarios:
- rising-only and falling-only edges;
- both edges;
- high and low levels;
- an acknowledge racing a new edge;
- the two-cycle input latency.

Enable gating, pull and output wiring, and the handling of unmapped and read-only offsets are likewise shown only by the bench.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_PIN_LVL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DRV_VAL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DRV_EN    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SENSE_LVL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_BOTH_EDGE = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_POLARITY  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_RAW       = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_PEND      = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_ACK       = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_PULL_DIR  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_PULL_EN   = 8'h38;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] smp_i,
  input  logic [WIDTH-1:0] lvl_sel_i,
  input  logic [WIDTH-1:0] both_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] hit;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = smp_i[p] & ~prev_q[p];
    assign fall     = ~smp_i[p] & prev_q[p];
    assign edge_hit = both_i[p] ? (rise | fall) : (pol_i[p] ? rise : fall);
    assign lvl_hit  = ~(smp_i[p] ^ pol_i[p]);
    assign hit[p]   = lvl_sel_i[p] ? lvl_hit : edge_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= smp_i;
      // a new event wins over a coinciding acknowledge
      status_q <= (status_q & ~clr_i) | hit;
    end
  end

  assign status_o = status_q;

  // R9
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~status_q & $past(status_q & ~clr_i)) == '0));

  // R9
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(clr_i & ~hit)) == '0));

  // R5
  set_needs_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pin_in_i,
  output logic [NPINS-1:0] pin_out_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] pull_en_o,
  output logic [NPINS-1:0] pull_up_o,
  output logic             irq_o
);
  logic [NPINS-1:0] wval;
  logic [NPINS-1:0] dout_q, oe_q, lvl_q, both_q, pol_q, mask_q, pdir_q, pen_q;
  logic [NPINS-1:0] pin_smp, status, pend, clr;
  logic [NPINS-1:0] rd_val;

  assign wval = wdata_i[NPINS-1:0];

  gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (pin_smp)
  );

  assign clr = (wr_en_i && addr_i == OFF_ACK) ? wval : '0;

  gpio_irq_detect #(.WIDTH(NPINS)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (pin_smp),
    .lvl_sel_i(lvl_q),
    .both_i   (both_q),
    .pol_i    (pol_q),
    .clr_i    (clr),
    .status_o (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      oe_q   <= '0;
      lvl_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
      pdir_q <= '0;
      pen_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_DRV_VAL:   dout_q <= wval;
        OFF_DRV_EN:    oe_q   <= wval;
        OFF_SENSE_LVL: lvl_q  <= wval;
        OFF_BOTH_EDGE: both_q <= wval;
        OFF_POLARITY:  pol_q  <= wval;
        OFF_IRQ_EN:    mask_q <= wval;
        OFF_PULL_DIR:  pdir_q <= wval;
        OFF_PULL_EN:   pen_q  <= wval;
        default: ;
      endcase
    end
  end

  assign pend = status & mask_q;

  always_comb begin
    case (addr_i)
      OFF_PIN_LVL:   rd_val = pin_smp;
      OFF_DRV_VAL:   rd_val = dout_q;
      OFF_DRV_EN:    rd_val = oe_q;
      OFF_SENSE_LVL: rd_val = lvl_q;
      OFF_BOTH_EDGE: rd_val = both_q;
      OFF_POLARITY:  rd_val = pol_q;
      OFF_IRQ_EN:    rd_val = mask_q;
      OFF_RAW:       rd_val = status;
      OFF_PEND:      rd_val = pend;
      OFF_PULL_DIR:  rd_val = pdir_q;
      OFF_PULL_EN:   rd_val = pen_q;
      default:       rd_val = '0;
    endcase
    rdata_o = '0;
    rdata_o[NPINS-1:0] = rd_val;
  end

  assign pin_out_o = dout_q & oe_q;
  assign pin_oe_o  = oe_q;
  assign pull_en_o = pen_q;
  assign pull_up_o = pdir_q;
  assign irq_o     = |pend;

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));

  // R9
  ack_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_ACK) |-> (rdata_o == '0));
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out, pin_oe, pull_en, pull_up;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pins),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .pull_en_o(pull_en),
    .pull_up_o(pull_up), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(8'h04, v); chk("R1 dout", v, 0);
    rd(8'h08, v); chk("R1 oe", v, 0);
    rd(8'h0C, v); chk("R1 sense", v, 0);
    rd(8'h18, v); chk("R1 mask", v, 0);
    rd(8'h1C, v); chk("R1 raw", v, 0);
    rd(8'h38, v); chk("R1 pull_en reg", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pull pins", pull_en | pull_up, 0);
  endtask

  task automatic test_outputs();
    logic [31:0] v;
    wr(8'h04, 32'hA5A5_0F0F);
    #1 chk("R3 no drive without enable", pin_out, 0);
    wr(8'h08, 32'hFFFF_0000);
    #1 chk("R3 pin_out", pin_out, 32'hA5A5_0000);
    chk("R3 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(8'h04, v); chk("R3 dout readback", v, 32'hA5A5_0F0F);
    rd(8'h08, v); chk("R3 oe readback", v, 32'hFFFF_0000);
  endtask

  task automatic test_pull();
    logic [31:0] v;
    wr(8'h38, 32'h0000_00F0);
    wr(8'h34, 32'h0000_0030);
    #1 chk("R4 pull_en", pull_en, 32'h0000_00F0);
    chk("R4 pull_up", pull_up, 32'h0000_0030);
    rd(8'h34, v); chk("R4 dir readback", v, 32'h0000_0030);
    rd(8'h38, v); chk("R4 en readback", v, 32'h0000_00F0);
  endtask

  task automatic test_datain();
    @(negedge clk);
    addr = 8'h00;
    pins = 32'h1234_8001;
    @(negedge clk);
    #1 chk("R2 not yet after one edge", rdata, 0);
    @(negedge clk);
    #1 chk("R2 visible after two edges", rdata, 32'h1234_8001);
    pins = 0;
    settle();
    wr(8'h24, 32'hFFFF_FFFF);
  endtask

  task automatic test_edge();
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h0C, 0); wr(8'h10, 0);
    wr(8'h14, 32'h0000_0002);
    pins[1] = 1'b1; pins[2] = 1'b1;
    settle();
    rd(8'h1C, v); chk("R5 rising only on pin1", v & 32'h6, 32'h2);
    pins[1] = 1'b0; pins[2] = 1'b0;
    settle();
    rd(8'h1C, v); chk("R5 falling on pin2", v & 32'h6, 32'h6);
    wr(8'h24, 32'h2);
    rd(8'h1C, v); chk("R9 selective clear", v & 32'h6, 32'h4);
    wr(8'h24, 32'h0);
    rd(8'h1C, v); chk("R9 zero write no effect", v & 32'h6, 32'h4);
    rd(8'h24, v); chk("R9 ack reads zero", v, 0);
  endtask

  task automatic test_dual();
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0008);
    wr(8'h14, 32'h0);
    pins[3] = 1'b1;
    settle();
    rd(8'h1C, v); chk("R6 rise with polarity 0", v & 32'h8, 32'h8);
    wr(8'h24, 32'h8);
    pins[3] = 1'b0;
    settle();
    rd(8'h1C, v); chk("R6 fall", v & 32'h8, 32'h8);
    wr(8'h10, 0);
  endtask

  task automatic test_level();
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_0080);
    wr(8'h0C, 32'h0000_0180);
    settle();
    rd(8'h1C, v); chk("R7 low level pin8 / idle pin7", v & 32'h180, 32'h100);
    pins[7] = 1'b1;
    settle();
    wr(8'h24, 32'h180);
    rd(8'h1C, v); chk("R7 ack ineffective while active", v & 32'h180, 32'h180);
    pins[7] = 1'b0; pins[8] = 1'b1;
    settle();
    wr(8'h24, 32'h180);
    rd(8'h1C, v); chk("R7 ack after level gone", v & 32'h180, 0);
    wr(8'h0C, 0);
  endtask

  task automatic test_mask();
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_0400);
    wr(8'h18, 0);
    pins[10] = 1'b1;
    settle();
    rd(8'h1C, v); chk("R8 raw ignores enable", v & 32'h400, 32'h400);
    rd(8'h20, v); chk("R8 masked zero", v, 0);
    chk("R10 irq low when disabled", {31'b0, irq}, 0);
    wr(8'h18, 32'h0000_0400);
    rd(8'h20, v); chk("R8 masked", v, 32'h400);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(8'h24, 32'h400);
    #1 chk("R10 irq low after ack", {31'b0, irq}, 0);
    wr(8'h18, 0);
  endtask

  task automatic test_race();
    logic [31:0] v;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_1000);
    pins[12] = 1'b1;
    settle();
    rd(8'h1C, v); chk("R6 pin12 set", v & 32'h1000, 32'h1000);
    @(negedge clk);
    pins[12] = 1'b0;
    @(negedge clk);
    wr(8'h24, 32'h1000); // lands on the edge the fall is detected
    rd(8'h1C, v); chk("R9 event beats ack", v & 32'h1000, 32'h1000);
    wr(8'h24, 32'h1000);
    rd(8'h1C, v); chk("R9 later ack clears", v & 32'h1000, 0);
  endtask

  task automatic test_unmapped();
    logic [31:0] v;
    rd(8'h28, v); chk("R11 unmapped 0x28", v, 0);
    rd(8'h2C, v); chk("R11 unmapped 0x2C", v, 0);
    rd(8'h3C, v); chk("R11 unmapped 0x3C", v, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R11 pin level not writable", v, pins);
    pins[12] = 1'b1;
    settle();
    wr(8'h1C, 0);
    wr(8'h20, 0);
    rd(8'h1C, v); chk("R11 raw not writable", v & 32'h1000, 32'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    test_outputs();
    test_pull();
    test_datain();
    test_edge();
    test_dual();
    test_level();
    test_mask();
    test_race();
    test_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule